// File: doc/BRIEF.md
# Bypass Source Location Scoreboard

This block keeps, for every physical register, a short code that says where a consumer should take that register's value from. The code is either the number of a bypass path or a reserved value meaning "read the register file". The code goes straight to the bypass multiplexer selects in the operand-read stage. The lookup needs only the source tag, so it can run alongside the register file read.

Each value updates its entry twice. The first update comes when the producer is scheduled, and it sets the entry to that producer's bypass path. The second comes when the value has been written to the register file, and it sets the entry back to the register-file code.

There are two issue lanes. Each lane has one schedule update port, one writeback update port and two source lookup ports. An update made in a cycle is forwarded to every lookup in that same cycle. This lets an instruction that issues alongside the update source its operand correctly.

Top module: `bypass_loc_sb`

## Requirements
- R1: After reset, and in the first cycle after reset is released, every entry reads as the register-file code 3'b111.
- R2: A valid schedule update on lane L sets the entry for `sched_tag[L]` to `{1'b0, sched_path[L]}`, so paths 0 to 3 read as codes 0 to 3. A lookup of that tag in the same cycle already returns the new code, and the code stays until the entry is updated again.
- R3: A valid writeback update sets its entry to 3'b111. The new code is visible to lookups in the same cycle, and it persists after the clock edge.
- R4: When a schedule update and a writeback update name the same register in one cycle, the schedule update wins.
- R5: When both schedule lanes name the same register in one cycle, the path from lane 1 is stored.
- R6: An entry is left unchanged when no valid update names it. This includes an update port that presents a matching tag with its valid bit low.
- R7: All four lookup ports work independently. Any number of them may read the same tag in one cycle, and lookups never change the table.
- R8: A lookup result is always a path code from 0 to 3 or the register-file code 3'b111. Codes 4 to 6 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_vld | input | 2 | Schedule update valid, one bit per lane |
| sched_tag | input | 2x6 | Destination register of each scheduled producer |
| sched_path | input | 2x2 | Bypass path number of each scheduled producer |
| wb_vld | input | 2 | Writeback update valid, one bit per lane |
| wb_tag | input | 2x6 | Register whose value reached the register file |
| rd_tag | input | 4x6 | Source tags; index 2*lane+operand |
| rd_loc | output | 4x3 | Bypass select for each source tag |

## Verification
The bench targets same-cycle forwarding. A table that answered from registered state alone would return the stale code in the cycle an update lands. The bench also targets collisions:
- A schedule update and a writeback on one register. Getting this wrong would leave a freshly scheduled value pointing at the register file.
- Two schedule updates on one register. Getting this wrong would select the lane-0 path.

Other checks confirm that entries keep their codes across idle cycles. Further checks confirm that an update with its valid bit low, or an update to a neighbouring register, leaves an entry untouched. Reset is also reapplied in the middle of a run, to show that every entry returns to the register-file code.

// File: rtl/bypass_loc_pkg.sv
package bypass_loc_pkg;
    localparam int PATH_W = 2;
    localparam int LOC_W  = PATH_W + 1;

    typedef logic [PATH_W-1:0] path_t;
    typedef logic [LOC_W-1:0]  loc_t;

    localparam loc_t LOC_RF = '1;

    function automatic loc_t path_to_loc(input path_t p);
        return {1'b0, p};
    endfunction
endpackage

// File: rtl/bls_next.sv
module bls_next
    import bypass_loc_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int LANES    = 2,
    parameter int TAG_W    = 6
) (
    input  loc_t [NUM_REGS-1:0]         cur,
    input  logic [LANES-1:0]            sched_vld,
    input  logic [LANES-1:0][TAG_W-1:0] sched_tag,
    input  path_t [LANES-1:0]           sched_path,
    input  logic [LANES-1:0]            wb_vld,
    input  logic [LANES-1:0][TAG_W-1:0] wb_tag,
    output loc_t [NUM_REGS-1:0]         nxt
);
    // Later assignments win: writebacks first, then schedule lanes in
    // ascending order, so the highest scheduling lane has the final say.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
        loc_t val;
        always_comb begin
            val = cur[r];
            for (int l = 0; l < LANES; l++) begin
                if (wb_vld[l] && (wb_tag[l] == TAG_W'(r))) begin
                    val = LOC_RF;
                end
            end
            for (int l = 0; l < LANES; l++) begin
                if (sched_vld[l] && (sched_tag[l] == TAG_W'(r))) begin
                    val = path_to_loc(sched_path[l]);
                end
            end
        end
        assign nxt[r] = val;
    end
endmodule

// File: rtl/bls_read.sv
module bls_read
    import bypass_loc_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int NUM_RD   = 4,
    parameter int TAG_W    = 6
) (
    input  loc_t [NUM_REGS-1:0]          tbl,
    input  logic [NUM_RD-1:0][TAG_W-1:0] rd_tag,
    output loc_t [NUM_RD-1:0]            rd_loc
);
    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        assign rd_loc[p] = tbl[rd_tag[p]];
    end
endmodule

// File: rtl/bypass_loc_sb.sv
module bypass_loc_sb
    import bypass_loc_pkg::*;
#(
    parameter int NUM_REGS      = 64,
    parameter int LANES         = 2,
    parameter int SRCS_PER_LANE = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [LANES-1:0]                             sched_vld,
    input  logic [LANES-1:0][$clog2(NUM_REGS)-1:0]       sched_tag,
    input  logic [LANES-1:0][bypass_loc_pkg::PATH_W-1:0] sched_path,
    input  logic [LANES-1:0]                             wb_vld,
    input  logic [LANES-1:0][$clog2(NUM_REGS)-1:0]       wb_tag,
    input  logic [LANES*SRCS_PER_LANE-1:0][$clog2(NUM_REGS)-1:0] rd_tag,
    output logic [LANES*SRCS_PER_LANE-1:0][bypass_loc_pkg::LOC_W-1:0] rd_loc
);
    localparam int TAG_W  = $clog2(NUM_REGS);
    localparam int NUM_RD = LANES * SRCS_PER_LANE;

    typedef struct packed {
        loc_t [NUM_REGS-1:0] entry;
    } state_t;

    state_t              state_q, state_d;
    loc_t [NUM_REGS-1:0] tbl_nxt;
    path_t [LANES-1:0]   path_in;
    loc_t [NUM_RD-1:0]   loc_out;

    assign path_in = sched_path;

    bls_next #(
        .NUM_REGS(NUM_REGS),
        .LANES   (LANES),
        .TAG_W   (TAG_W)
    ) u_next (
        .cur       (state_q.entry),
        .sched_vld (sched_vld),
        .sched_tag (sched_tag),
        .sched_path(path_in),
        .wb_vld    (wb_vld),
        .wb_tag    (wb_tag),
        .nxt       (tbl_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.entry = tbl_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.entry <= {NUM_REGS{LOC_RF}};
        end else begin
            state_q <= state_d;
        end
    end

    // Lookups see this cycle's updates: same-cycle forwarding.
    bls_read #(
        .NUM_REGS(NUM_REGS),
        .NUM_RD  (NUM_RD),
        .TAG_W   (TAG_W)
    ) u_read (
        .tbl   (state_d.entry),
        .rd_tag(rd_tag),
        .rd_loc(loc_out)
    );

    assign rd_loc = loc_out;
endmodule

// File: rtl/bypass_loc_sb_chk.sv
module bypass_loc_sb_chk
    import bypass_loc_pkg::*;
#(
    parameter int NUM_REGS      = 64,
    parameter int LANES         = 2,
    parameter int SRCS_PER_LANE = 2
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic [LANES-1:0]                             sched_vld,
    input logic [LANES-1:0][$clog2(NUM_REGS)-1:0]       sched_tag,
    input logic [LANES-1:0][bypass_loc_pkg::PATH_W-1:0] sched_path,
    input logic [LANES-1:0]                             wb_vld,
    input logic [LANES-1:0][$clog2(NUM_REGS)-1:0]       wb_tag,
    input logic [LANES*SRCS_PER_LANE-1:0][$clog2(NUM_REGS)-1:0] rd_tag,
    input logic [LANES*SRCS_PER_LANE-1:0][bypass_loc_pkg::LOC_W-1:0] rd_loc
);
    localparam int NUM_RD = LANES * SRCS_PER_LANE;

    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        logic [LANES-1:0] s_hit, w_hit;
        always_comb begin
            for (int l = 0; l < LANES; l++) begin
                s_hit[l] = sched_vld[l] && (sched_tag[l] == rd_tag[p]);
                w_hit[l] = wb_vld[l] && (wb_tag[l] == rd_tag[p]);
            end
        end

        // R1: first cycle out of reset, untouched entries read register file
        a_r1_reset_rf: assert property (@(posedge clk) disable iff (!rst_n)
            (!past_ok_q && !(|s_hit) && !(|w_hit)) |-> (rd_loc[p] == LOC_RF));

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // R2, R4, R5: winning schedule lane is forwarded
            a_r2_sched_fwd: assert property (@(posedge clk) disable iff (!rst_n)
                (s_hit[l] && ((s_hit >> (l + 1)) == '0))
                |-> (rd_loc[p] == {1'b0, sched_path[l]}));
        end

        // R3: writeback without competing schedule reads register file
        a_r3_wb_fwd: assert property (@(posedge clk) disable iff (!rst_n)
            ((|w_hit) && !(|s_hit)) |-> (rd_loc[p] == LOC_RF));

        // R4: schedule beats writeback on the same register
        a_r4_sched_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ((|w_hit) && (|s_hit)) |-> (rd_loc[p] != LOC_RF));

        // R6: no update to a held tag keeps the previous answer
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok_q && (rd_tag[p] == $past(rd_tag[p])) && !(|s_hit) && !(|w_hit))
            |-> (rd_loc[p] == $past(rd_loc[p])));

        // R8: only path codes or the register-file code appear
        a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_loc[p][LOC_W-1] == 1'b0) || (rd_loc[p] == LOC_RF));
    end
endmodule

bind bypass_loc_sb bypass_loc_sb_chk #(
    .NUM_REGS     (NUM_REGS),
    .LANES        (LANES),
    .SRCS_PER_LANE(SRCS_PER_LANE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sched_vld (sched_vld),
    .sched_tag (sched_tag),
    .sched_path(sched_path),
    .wb_vld    (wb_vld),
    .wb_tag    (wb_tag),
    .rd_tag    (rd_tag),
    .rd_loc    (rd_loc)
);

// File: tb/bypass_loc_sb_tb.sv
module bypass_loc_sb_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]      sched_vld;
    logic [1:0][5:0] sched_tag;
    logic [1:0][1:0] sched_path;
    logic [1:0]      wb_vld;
    logic [1:0][5:0] wb_tag;
    logic [3:0][5:0] rd_tag;
    logic [3:0][2:0] rd_loc;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    bypass_loc_sb u_dut (
        .clk(clk), .rst_n(rst_n),
        .sched_vld(sched_vld), .sched_tag(sched_tag), .sched_path(sched_path),
        .wb_vld(wb_vld), .wb_tag(wb_tag),
        .rd_tag(rd_tag), .rd_loc(rd_loc)
    );

    typedef struct packed {
        logic [1:0] sv;
        logic [5:0] st0, st1;
        logic [1:0] sp0, sp1;
        logic [1:0] wv;
        logic [5:0] wt0, wt1;
        logic [5:0] r0, r1, r2, r3;
        logic [2:0] e0, e1, e2, e3;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R1: fresh table reads register file
        '{2'b00, 6'd0, 6'd0, 2'd0, 2'd0, 2'b00, 6'd0, 6'd0, 6'd0, 6'd5, 6'd63, 6'd10, 3'd7, 3'd7, 3'd7, 3'd7, 4'd1},
        // R2 forward, R7 same tag on two ports
        '{2'b01, 6'd5, 6'd0, 2'd2, 2'd0, 2'b00, 6'd0, 6'd0, 6'd5, 6'd5, 6'd6, 6'd0, 3'd2, 3'd2, 3'd7, 3'd7, 4'd2},
        // R2 persistence
        '{2'b00, 6'd0, 6'd0, 2'd0, 2'd0, 2'b00, 6'd0, 6'd0, 6'd6, 6'd5, 6'd63, 6'd0, 3'd7, 3'd2, 3'd7, 3'd7, 4'd2},
        // R3 writeback forward
        '{2'b00, 6'd0, 6'd0, 2'd0, 2'd0, 2'b10, 6'd0, 6'd5, 6'd5, 6'd4, 6'd5, 6'd6, 3'd7, 3'd7, 3'd7, 3'd7, 4'd3},
        // R3 persistence
        '{2'b00, 6'd0, 6'd0, 2'd0, 2'd0, 2'b00, 6'd0, 6'd0, 6'd5, 6'd5, 6'd5, 6'd5, 3'd7, 3'd7, 3'd7, 3'd7, 4'd3},
        // R5 lane 1 wins a schedule collision
        '{2'b11, 6'd9, 6'd9, 2'd1, 2'd3, 2'b00, 6'd0, 6'd0, 6'd9, 6'd5, 6'd9, 6'd8, 3'd3, 3'd7, 3'd3, 3'd7, 4'd5},
        // R4 schedule beats writeback
        '{2'b10, 6'd0, 6'd12, 2'd0, 2'd0, 2'b01, 6'd12, 6'd0, 6'd12, 6'd9, 6'd5, 6'd0, 3'd0, 3'd3, 3'd7, 3'd7, 4'd4},
        // R4 and R5 outcomes persist
        '{2'b00, 6'd0, 6'd0, 2'd0, 2'd0, 2'b00, 6'd0, 6'd0, 6'd12, 6'd9, 6'd5, 6'd63, 3'd0, 3'd3, 3'd7, 3'd7, 4'd4},
        // R7 four distinct updates in one cycle
        '{2'b11, 6'd63, 6'd0, 2'd1, 2'd2, 2'b11, 6'd9, 6'd12, 6'd63, 6'd0, 6'd9, 6'd12, 3'd1, 3'd2, 3'd7, 3'd7, 4'd7},
        // R6 entries held across idle cycle
        '{2'b00, 6'd0, 6'd0, 2'd0, 2'd0, 2'b00, 6'd0, 6'd0, 6'd63, 6'd0, 6'd9, 6'd12, 3'd1, 3'd2, 3'd7, 3'd7, 4'd6},
        // R4 cross-lane schedule beats writeback
        '{2'b01, 6'd20, 6'd0, 2'd3, 2'd0, 2'b10, 6'd0, 6'd20, 6'd20, 6'd20, 6'd21, 6'd63, 3'd3, 3'd3, 3'd7, 3'd1, 4'd4}
    };

    task automatic check(input int req, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL R%0d: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle();
        sched_vld = '0; sched_tag = '0; sched_path = '0;
        wb_vld = '0; wb_tag = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle();
        rd_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            sched_vld     = VECS[i].sv;
            sched_tag[0]  = VECS[i].st0;  sched_tag[1]  = VECS[i].st1;
            sched_path[0] = VECS[i].sp0;  sched_path[1] = VECS[i].sp1;
            wb_vld        = VECS[i].wv;
            wb_tag[0]     = VECS[i].wt0;  wb_tag[1]     = VECS[i].wt1;
            rd_tag[0] = VECS[i].r0; rd_tag[1] = VECS[i].r1;
            rd_tag[2] = VECS[i].r2; rd_tag[3] = VECS[i].r3;
            #1;
            check(int'(VECS[i].req), rd_loc[0], VECS[i].e0);
            check(int'(VECS[i].req), rd_loc[1], VECS[i].e1);
            check(int'(VECS[i].req), rd_loc[2], VECS[i].e2);
            check(int'(VECS[i].req), rd_loc[3], VECS[i].e3);
            @(negedge clk);
        end

        // R6: invalid updates carrying a matching tag have no effect
        idle();
        sched_tag[0] = 6'd30; sched_path[0] = 2'd1;
        sched_tag[1] = 6'd30; sched_path[1] = 2'd2;
        wb_tag[0] = 6'd63; wb_tag[1] = 6'd0;
        rd_tag[0] = 6'd30; rd_tag[1] = 6'd63; rd_tag[2] = 6'd0; rd_tag[3] = 6'd31;
        #1;
        check(6, rd_loc[0], 3'd7);
        check(6, rd_loc[1], 3'd1);
        check(6, rd_loc[2], 3'd2);
        @(negedge clk);
        idle();
        #1;
        check(6, rd_loc[0], 3'd7);
        check(6, rd_loc[1], 3'd1);
        check(6, rd_loc[3], 3'd7);

        // R8: every path number maps to its own code, neighbour untouched
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle();
            sched_vld = 2'b01; sched_tag[0] = 6'd40; sched_path[0] = 2'(k);
            rd_tag[0] = 6'd40; rd_tag[1] = 6'd41;
            #1;
            check(8, rd_loc[0], 3'(k));
            check(6, rd_loc[1], 3'd7);
        end

        // R1: reset in mid-run clears every entry
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_tag[0] = 6'd63; rd_tag[1] = 6'd0; rd_tag[2] = 6'd9; rd_tag[3] = 6'd40;
        #1;
        check(1, rd_loc[0], 3'd7);
        check(1, rd_loc[1], 3'd7);
        check(1, rd_loc[2], 3'd7);
        check(1, rd_loc[3], 3'd7);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule